// File: doc/BRIEF.md
# Word-to-Byte Data Port

This block connects the 32-bit data registers of an SPI host to two byte-wide queues. A write request carrying a 32-bit word splits it into four bytes and loads them into the transmit queue one per clock, lowest byte first. A read request unloads up to four bytes from the receive queue one per clock and packs them into a word, lowest byte in the lowest lane. While a word access is in progress the port holds the bus with a wait signal, then pulses a done strobe.

Because the bus side is word-wide and the queue side is byte-wide, an access can stop partway: a transmit queue that fills up halts a write with an overflow pulse, and a receive queue that runs dry ends a read early with an underflow pulse, returning only the bytes already gathered. The port also keeps the full and empty status flags that the interrupt logic watches, and a count of completed transmit words. The shift engine of the SPI host drains the transmit queue and fills the receive queue through the byte-side ports, and either queue can be flushed.

Top module: `spi_word_byte_port`

## Requirements
- R1: An accepted write of word W loads bytes into the transmit queue one per clock, lane 0 first, where lane i holds bits 8i+7 down to 8i; the shift side sees them at `tx_byte` in that order.
- R2: When the transmit queue holds TX_DEPTH bytes at the clock where a lane is due, loading stops, the remaining lanes are discarded, `tx_full` becomes 1, `err_overflow` is high for exactly one cycle and `tx_words` does not change.
- R3: A write whose four lanes are all loaded clears `tx_empty` and adds one to `tx_words` (saturating at its all-ones value).
- R4: An accepted read clears `rx_full` in its acceptance clock, then unloads up to four bytes, placing the i-th byte at bits 8i+7 down to 8i of `rd_data`.
- R5: When the receive queue is empty at the clock where a lane is due, the read ends, `rd_data` holds the bytes gathered so far with all higher bits zero, `rx_empty` becomes 1 and `err_underflow` is high for exactly one cycle.
- R6: A flush of the transmit queue empties it, clears `tx_full`, sets `tx_empty` and zeroes `tx_words`; a flush of the receive queue empties it, clears `rx_full` and sets `rx_empty`. A flush takes priority over any other update of that queue in the same clock.
- R7: After reset both queues are empty, `tx_empty` and `rx_empty` are 1, `tx_full`, `rx_full`, `tx_words`, `acc_wait`, `acc_done`, both error pulses and `rd_data` are 0.
- R8: `tx_byte_valid` is 1 whenever the transmit queue is non-empty and `tx_byte` is its oldest byte; `tx_pop` removes it. An `rx_push` into a receive queue holding RX_DEPTH bytes is dropped and sets `rx_full`; an accepted `rx_push` clears `rx_empty`.
- R9: A request is accepted at a clock where `acc_wait` is 0; `acc_wait` is 1 from the next cycle until the access ends, at most four cycles; `acc_done` is high for one cycle as `acc_wait` falls, and a new request may be accepted in that same cycle.
- R10: When a clear and a set of the same flag fall in one clock, the set wins: a dropped `rx_push` in the clock a read is accepted leaves `rx_full` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_flush | input | 1 | Empty the transmit queue |
| rx_flush | input | 1 | Empty the receive queue |
| wr_req | input | 1 | Write request (transmit word) |
| wr_data | input | 32 | Word to transmit |
| rd_req | input | 1 | Read request (receive word) |
| rd_data | output | 32 | Word returned by the last read |
| acc_wait | output | 1 | Bus held while a word access runs |
| acc_done | output | 1 | One-cycle strobe at the end of an access |
| tx_byte_valid | output | 1 | Transmit queue non-empty |
| tx_byte | output | 8 | Oldest transmit byte |
| tx_pop | input | 1 | Shift side takes the oldest transmit byte |
| rx_push | input | 1 | Shift side delivers a received byte |
| rx_byte | input | 8 | Received byte |
| tx_full | output | 1 | Transmit overflow status flag |
| tx_empty | output | 1 | Transmit empty status flag |
| tx_words | output | clog2(TX_DEPTH/4+1) | Completed transmit words since flush |
| rx_full | output | 1 | Receive full status flag |
| rx_empty | output | 1 | Receive empty status flag |
| err_overflow | output | 1 | One-cycle overflow error pulse |
| err_underflow | output | 1 | One-cycle underflow error pulse |

## Verification
The assertions take for granted that a request never arrives while `acc_wait` is high, that write and read are never requested in the same clock, and that a flush is only applied while the port is idle. The stimulus keeps within this by raising a request only at a falling clock edge where `acc_wait` is low, including the cycle of `acc_done` for back-to-back accesses, and by waiting for idle before each flush. Byte-side pops and pushes are free to collide with word accesses, and the reference model follows those collisions cycle by cycle.

// File: rtl/wbp_pkg.sv
package wbp_pkg;

    localparam int unsigned BUS_W  = 32;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned LANES  = BUS_W / BYTE_W;
    localparam int unsigned LANE_W = $clog2(LANES);

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_LOAD = 2'd1,
        ENG_GATHER = 2'd2
    } eng_state_e;

    typedef struct packed {
        eng_state_e         state;
        logic [LANE_W-1:0]  lane;
        logic [BUS_W-1:0]   word;
        logic               done;
        logic [BUS_W-1:0]   rd_word;
    } eng_regs_t;

endpackage

// File: rtl/wbp_byte_fifo.sv
module wbp_byte_fifo #(
    parameter int unsigned DEPTH = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  logic       push,
    input  logic [7:0] push_byte,
    input  logic       pop,
    output logic [7:0] head,
    output logic       has_space,
    output logic       has_data
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [CNT_W-1:0] count;
    } fifo_regs_t;

    fifo_regs_t r_d, r_q;
    logic [7:0] mem [DEPTH];
    logic push_ok, pop_ok;

    assign has_space = (r_q.count != FULL_CNT);
    assign has_data  = (r_q.count != '0);
    assign head      = mem[r_q.rptr];

    always_comb begin
        r_d     = r_q;
        push_ok = push && has_space && !flush;
        pop_ok  = pop && has_data && !flush;
        if (push_ok) begin
            r_d.wptr = (r_q.wptr == LAST_PTR) ? '0 : r_q.wptr + 1'b1;
        end
        if (pop_ok) begin
            r_d.rptr = (r_q.rptr == LAST_PTR) ? '0 : r_q.rptr + 1'b1;
        end
        case ({push_ok, pop_ok})
            2'b10:   r_d.count = r_q.count + 1'b1;
            2'b01:   r_d.count = r_q.count - 1'b1;
            default: r_d.count = r_q.count;
        endcase
        if (flush) begin
            r_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[r_q.wptr] <= push_byte;
        end
    end

    // R6: a flush leaves the queue empty
    a_r6_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (r_q.count == '0));

    // R8: a push into a full queue without a pop leaves it full
    a_r8_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!has_space && push && !pop && !flush) |=> !has_space);

    // R8: occupancy never exceeds the depth
    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.count <= FULL_CNT);

endmodule

// File: rtl/wbp_engine.sv
module wbp_engine
    import wbp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [BUS_W-1:0]  wr_word,
    input  logic              rd_req,
    input  logic              tx_space,
    input  logic              rx_avail,
    input  logic [7:0]        rx_head,
    output logic              tx_push,
    output logic [7:0]        tx_push_byte,
    output logic              rx_pop,
    output logic              busy,
    output logic              done,
    output logic [BUS_W-1:0]  rd_word,
    output logic              ev_wr_done,
    output logic              ev_ovf,
    output logic              ev_rd_start,
    output logic              ev_unf
);
    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

    eng_regs_t r_d, r_q;
    logic [4:0] shamt;
    logic [BUS_W-1:0] gathered;

    assign busy    = (r_q.state != ENG_IDLE);
    assign done    = r_q.done;
    assign rd_word = r_q.rd_word;

    always_comb begin
        r_d          = r_q;
        r_d.done     = 1'b0;
        tx_push      = 1'b0;
        rx_pop       = 1'b0;
        ev_wr_done   = 1'b0;
        ev_ovf       = 1'b0;
        ev_rd_start  = 1'b0;
        ev_unf       = 1'b0;
        shamt        = {r_q.lane, 3'b000};
        tx_push_byte = 8'(r_q.word >> shamt);
        gathered     = r_q.word | (BUS_W'(rx_head) << shamt);
        case (r_q.state)
            ENG_IDLE: begin
                if (wr_req) begin
                    r_d.state = ENG_LOAD;
                    r_d.lane  = '0;
                    r_d.word  = wr_word;
                end else if (rd_req) begin
                    r_d.state   = ENG_GATHER;
                    r_d.lane    = '0;
                    r_d.word    = '0;
                    ev_rd_start = 1'b1;
                end
            end
            ENG_LOAD: begin
                if (!tx_space) begin
                    ev_ovf    = 1'b1;
                    r_d.state = ENG_IDLE;
                    r_d.done  = 1'b1;
                end else begin
                    tx_push = 1'b1;
                    if (r_q.lane == LAST_LANE) begin
                        ev_wr_done = 1'b1;
                        r_d.state  = ENG_IDLE;
                        r_d.done   = 1'b1;
                    end else begin
                        r_d.lane = r_q.lane + 1'b1;
                    end
                end
            end
            ENG_GATHER: begin
                if (!rx_avail) begin
                    ev_unf      = 1'b1;
                    r_d.state   = ENG_IDLE;
                    r_d.done    = 1'b1;
                    r_d.rd_word = r_q.word;
                end else begin
                    rx_pop   = 1'b1;
                    r_d.word = gathered;
                    if (r_q.lane == LAST_LANE) begin
                        r_d.state   = ENG_IDLE;
                        r_d.done    = 1'b1;
                        r_d.rd_word = gathered;
                    end else begin
                        r_d.lane = r_q.lane + 1'b1;
                    end
                end
            end
            default: r_d.state = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ENG_IDLE, lane: '0, word: '0, done: 1'b0, rd_word: '0};
        end else begin
            r_q <= r_d;
        end
    end

    // R1: a lane past the first is only loaded after loading the previous one
    a_r1_lane_order: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ENG_LOAD && r_q.lane != '0) |-> ($past(tx_push) && $past(r_q.state) == ENG_LOAD));

    // R2: an overflow ends the write at once
    a_r2_ovf_stops: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ovf |=> (done && !busy));

    // R5: an underflow ends the read at once
    a_r5_unf_stops: assert property (@(posedge clk) disable iff (!rst_n)
        ev_unf |=> (done && !busy));

    // R9: the done strobe only follows a busy cycle
    a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

endmodule

// File: rtl/wbp_flags.sv
module wbp_flags #(
    parameter int unsigned TX_DEPTH = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_flush,
    input  logic rx_flush,
    input  logic ev_wr_done,
    input  logic ev_ovf,
    input  logic ev_rd_start,
    input  logic ev_unf,
    input  logic rx_push,
    input  logic rx_space,
    output logic tx_full,
    output logic tx_empty,
    output logic [$clog2(TX_DEPTH/4+1)-1:0] tx_words,
    output logic rx_full,
    output logic rx_empty,
    output logic err_overflow,
    output logic err_underflow
);
    localparam int unsigned WCNT_W = $clog2(TX_DEPTH / 4 + 1);
    localparam logic [WCNT_W-1:0] WCNT_MAX = '1;

    typedef struct packed {
        logic              tx_full;
        logic              tx_empty;
        logic [WCNT_W-1:0] words;
        logic              rx_full;
        logic              rx_empty;
        logic              ovf;
        logic              unf;
    } flag_regs_t;

    flag_regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.ovf = ev_ovf;
        r_d.unf = ev_unf;
        // transmit side
        if (ev_ovf) begin
            r_d.tx_full = 1'b1;
        end
        if (ev_wr_done) begin
            r_d.tx_empty = 1'b0;
            if (r_q.words != WCNT_MAX) begin
                r_d.words = r_q.words + 1'b1;
            end
        end
        if (tx_flush) begin
            r_d.tx_full  = 1'b0;
            r_d.tx_empty = 1'b1;
            r_d.words    = '0;
        end
        // receive side: clears first, sets after so that a set wins
        if (ev_rd_start) begin
            r_d.rx_full = 1'b0;
        end
        if (rx_push && rx_space) begin
            r_d.rx_empty = 1'b0;
        end
        if (rx_push && !rx_space) begin
            r_d.rx_full = 1'b1;
        end
        if (ev_unf) begin
            r_d.rx_empty = 1'b1;
        end
        if (rx_flush) begin
            r_d.rx_full  = 1'b0;
            r_d.rx_empty = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{tx_full: 1'b0, tx_empty: 1'b1, words: '0, rx_full: 1'b0,
                     rx_empty: 1'b1, ovf: 1'b0, unf: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign tx_full       = r_q.tx_full;
    assign tx_empty      = r_q.tx_empty;
    assign tx_words      = r_q.words;
    assign rx_full       = r_q.rx_full;
    assign rx_empty      = r_q.rx_empty;
    assign err_overflow  = r_q.ovf;
    assign err_underflow = r_q.unf;

    // R2: an overflow raises the transmit full flag and leaves the count alone
    a_r2_full_after_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_ovf && !tx_flush) |=> (tx_full && $stable(tx_words)));

    // R3: a completed write clears the transmit empty flag
    a_r3_empty_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_wr_done && !tx_flush) |=> !tx_empty);

    // R4: read acceptance clears the receive full flag unless a dropped push sets it
    a_r4_full_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rd_start && !(rx_push && !rx_space)) |=> !rx_full);

    // R5: an underflow sets the receive empty flag
    a_r5_empty_after_unf: assert property (@(posedge clk) disable iff (!rst_n)
        ev_unf |=> rx_empty);

    // R6: a transmit flush restores the idle flags
    a_r6_tx_flush: assert property (@(posedge clk) disable iff (!rst_n)
        tx_flush |=> (tx_empty && !tx_full && tx_words == '0));

    // R10: a dropped push in the read acceptance clock leaves the full flag set
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rd_start && rx_push && !rx_space && !rx_flush) |=> rx_full);

endmodule

// File: rtl/spi_word_byte_port.sv
module spi_word_byte_port
    import wbp_pkg::*;
#(
    parameter int unsigned TX_DEPTH = 64,
    parameter int unsigned RX_DEPTH = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tx_flush,
    input  logic        rx_flush,
    input  logic        wr_req,
    input  logic [31:0] wr_data,
    input  logic        rd_req,
    output logic [31:0] rd_data,
    output logic        acc_wait,
    output logic        acc_done,
    output logic        tx_byte_valid,
    output logic [7:0]  tx_byte,
    input  logic        tx_pop,
    input  logic        rx_push,
    input  logic [7:0]  rx_byte,
    output logic        tx_full,
    output logic        tx_empty,
    output logic [$clog2(TX_DEPTH/4+1)-1:0] tx_words,
    output logic        rx_full,
    output logic        rx_empty,
    output logic        err_overflow,
    output logic        err_underflow
);
    logic       tx_space, tx_push;
    logic [7:0] tx_push_byte;
    logic       rx_space, rx_avail, rx_pop;
    logic [7:0] rx_head;
    logic       ev_wr_done, ev_ovf, ev_rd_start, ev_unf;

    wbp_byte_fifo #(.DEPTH(TX_DEPTH)) i_tx_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (tx_flush),
        .push      (tx_push),
        .push_byte (tx_push_byte),
        .pop       (tx_pop),
        .head      (tx_byte),
        .has_space (tx_space),
        .has_data  (tx_byte_valid)
    );

    wbp_byte_fifo #(.DEPTH(RX_DEPTH)) i_rx_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (rx_flush),
        .push      (rx_push),
        .push_byte (rx_byte),
        .pop       (rx_pop),
        .head      (rx_head),
        .has_space (rx_space),
        .has_data  (rx_avail)
    );

    wbp_engine i_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_req       (wr_req),
        .wr_word      (wr_data),
        .rd_req       (rd_req),
        .tx_space     (tx_space),
        .rx_avail     (rx_avail),
        .rx_head      (rx_head),
        .tx_push      (tx_push),
        .tx_push_byte (tx_push_byte),
        .rx_pop       (rx_pop),
        .busy         (acc_wait),
        .done         (acc_done),
        .rd_word      (rd_data),
        .ev_wr_done   (ev_wr_done),
        .ev_ovf       (ev_ovf),
        .ev_rd_start  (ev_rd_start),
        .ev_unf       (ev_unf)
    );

    wbp_flags #(.TX_DEPTH(TX_DEPTH)) i_flags (
        .clk           (clk),
        .rst_n         (rst_n),
        .tx_flush      (tx_flush),
        .rx_flush      (rx_flush),
        .ev_wr_done    (ev_wr_done),
        .ev_ovf        (ev_ovf),
        .ev_rd_start   (ev_rd_start),
        .ev_unf        (ev_unf),
        .rx_push       (rx_push),
        .rx_space      (rx_space),
        .tx_full       (tx_full),
        .tx_empty      (tx_empty),
        .tx_words      (tx_words),
        .rx_full       (rx_full),
        .rx_empty      (rx_empty),
        .err_overflow  (err_overflow),
        .err_underflow (err_underflow)
    );

    // R9: input assumption, no request while the bus is held
    a_r9_no_req_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wait |-> (!wr_req && !rd_req));

    // R9: input assumption, never both requests together
    a_r9_one_req: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_req && rd_req));

    // R6: input assumption, flushes only while idle
    a_r6_flush_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_flush || rx_flush) |-> !acc_wait);

    // R9: the done strobe accompanies the fall of the wait signal
    a_r9_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(acc_wait) |-> acc_done);

endmodule

// File: tb/test_spi_word_byte_port.sv
module test_spi_word_byte_port;
    localparam int CLK_PERIOD = 10;
    localparam int TXD = 64;
    localparam int RXD = 64;
    localparam int WW = $clog2(TXD / 4 + 1);
    localparam int WMAX = (1 << WW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_flush = 0, rx_flush = 0, wr_req = 0, rd_req = 0, tx_pop = 0, rx_push = 0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rx_byte = '0;
    logic [31:0] rd_data;
    logic acc_wait, acc_done, tx_byte_valid, tx_full, tx_empty, rx_full, rx_empty;
    logic err_overflow, err_underflow;
    logic [7:0] tx_byte;
    logic [WW-1:0] tx_words;

    spi_word_byte_port #(.TX_DEPTH(TXD), .RX_DEPTH(RXD)) i_spi_word_byte_port (
        .clk(clk), .rst_n(rst_n), .tx_flush(tx_flush), .rx_flush(rx_flush),
        .wr_req(wr_req), .wr_data(wr_data), .rd_req(rd_req), .rd_data(rd_data),
        .acc_wait(acc_wait), .acc_done(acc_done), .tx_byte_valid(tx_byte_valid),
        .tx_byte(tx_byte), .tx_pop(tx_pop), .rx_push(rx_push), .rx_byte(rx_byte),
        .tx_full(tx_full), .tx_empty(tx_empty), .tx_words(tx_words),
        .rx_full(rx_full), .rx_empty(rx_empty), .err_overflow(err_overflow),
        .err_underflow(err_underflow)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit fin = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [7:0] txq[$];
    logic [7:0] rxq[$];
    int m_op, m_idx, m_words;
    logic [31:0] m_word, m_acc, m_rd;
    bit m_done, m_ovf, m_unf, f_txfull, f_txempty, f_rxfull, f_rxempty;
    int ptx, prx;
    bit tpop_ok, rx_clr_full, rx_set_full, rx_clr_empty, rx_set_empty;
    logic [7:0] junk;

    always @(posedge clk) begin
        if (!rst_n) begin
            txq.delete(); rxq.delete();
            m_op = 0; m_idx = 0; m_words = 0; m_word = 0; m_acc = 0; m_rd = 0;
            m_done = 0; m_ovf = 0; m_unf = 0;
            f_txfull = 0; f_txempty = 1; f_rxfull = 0; f_rxempty = 1;
        end else begin
            ptx = txq.size(); prx = rxq.size();
            tpop_ok = tx_pop && ptx > 0;
            rx_clr_full = 0; rx_set_full = 0; rx_clr_empty = 0; rx_set_empty = 0;
            m_done = 0; m_ovf = 0; m_unf = 0;
            if (m_op == 1) begin
                if (ptx == TXD) begin
                    m_ovf = 1; f_txfull = 1; m_op = 0; m_done = 1;
                end else begin
                    txq.push_back(m_word[8*m_idx +: 8]);
                    if (m_idx == 3) begin
                        m_op = 0; m_done = 1; f_txempty = 0;
                        if (m_words < WMAX) m_words++;
                    end else m_idx++;
                end
            end else if (m_op == 2) begin
                if (prx == 0) begin
                    m_unf = 1; rx_set_empty = 1; m_rd = m_acc; m_op = 0; m_done = 1;
                end else begin
                    m_acc = m_acc | (32'(rxq.pop_front()) << (8 * m_idx));
                    if (m_idx == 3) begin
                        m_rd = m_acc; m_op = 0; m_done = 1;
                    end else m_idx++;
                end
            end else if (wr_req) begin
                m_op = 1; m_idx = 0; m_word = wr_data;
            end else if (rd_req) begin
                m_op = 2; m_idx = 0; m_acc = 0; rx_clr_full = 1;
            end
            if (tpop_ok) junk = txq.pop_front();
            if (rx_push) begin
                if (prx == RXD) rx_set_full = 1;
                else begin
                    rxq.push_back(rx_byte); rx_clr_empty = 1;
                end
            end
            if (rx_clr_full) f_rxfull = 0;
            if (rx_clr_empty) f_rxempty = 0;
            if (rx_set_full) f_rxfull = 1;
            if (rx_set_empty) f_rxempty = 1;
            if (tx_flush) begin
                txq.delete(); f_txfull = 0; f_txempty = 1; m_words = 0;
            end
            if (rx_flush) begin
                rxq.delete(); f_rxfull = 0; f_rxempty = 1;
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !fin) begin
            chk("R9 acc_wait", 32'(acc_wait), 32'(m_op != 0));
            chk("R9 acc_done", 32'(acc_done), 32'(m_done));
            chk("R8 tx_byte_valid", 32'(tx_byte_valid), 32'(txq.size() > 0));
            if (txq.size() > 0) chk("R8 tx_byte", 32'(tx_byte), 32'(txq[0]));
            chk("R2 tx_full", 32'(tx_full), 32'(f_txfull));
            chk("R3 tx_empty", 32'(tx_empty), 32'(f_txempty));
            chk("R3 tx_words", 32'(tx_words), 32'(m_words));
            chk("R4 rx_full", 32'(rx_full), 32'(f_rxfull));
            chk("R5 rx_empty", 32'(rx_empty), 32'(f_rxempty));
            chk("R2 err_overflow", 32'(err_overflow), 32'(m_ovf));
            chk("R5 err_underflow", 32'(err_underflow), 32'(m_unf));
            chk("R4 rd_data", rd_data, m_rd);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !fin) begin
            fin = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    // ---------------- stimulus tasks (called at a falling edge) ----------------
    task automatic do_write(input logic [31:0] w, output bit ovf_seen);
        wr_req = 1; wr_data = w;
        @(negedge clk);
        wr_req = 0; ovf_seen = 0;
        while (acc_wait) begin
            @(negedge clk);
            ovf_seen |= err_overflow;
        end
    endtask

    task automatic do_read(output logic [31:0] w, output bit unf_seen);
        rd_req = 1;
        @(negedge clk);
        rd_req = 0; unf_seen = 0;
        while (acc_wait) begin
            @(negedge clk);
            unf_seen |= err_underflow;
        end
        w = rd_data;
    endtask

    task automatic pop_one(input logic [7:0] exp, input string tag);
        chk(tag, 32'(tx_byte), 32'(exp));
        tx_pop = 1;
        @(negedge clk);
        tx_pop = 0;
    endtask

    task automatic push_one(input logic [7:0] b);
        rx_push = 1; rx_byte = b;
        @(negedge clk);
        rx_push = 0;
    endtask

    task automatic flush_q(input bit tx, input bit rx);
        while (acc_wait) @(negedge clk);
        tx_flush = tx; rx_flush = rx;
        @(negedge clk);
        tx_flush = 0; rx_flush = 0;
    endtask

    initial begin
        bit flag;
        logic [31:0] w;
        int drained;
        logic [7:0] last1, last0;

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R7 reset state
        chk("R7 tx_empty", 32'(tx_empty), 1);
        chk("R7 rx_empty", 32'(rx_empty), 1);
        chk("R7 tx_full", 32'(tx_full), 0);
        chk("R7 rx_full", 32'(rx_full), 0);
        chk("R7 tx_words", 32'(tx_words), 0);
        chk("R7 acc_wait", 32'(acc_wait), 0);
        chk("R7 rd_data", rd_data, 0);
        chk("R7 tx_byte_valid", 32'(tx_byte_valid), 0);

        // R1 / R3: aligned word, least significant lane first
        do_write(32'h4433_2211, flag);
        chk("R3 tx_words after write", 32'(tx_words), 1);
        chk("R3 tx_empty after write", 32'(tx_empty), 0);
        chk("R2 no overflow on space", 32'(flag), 0);
        pop_one(8'h11, "R1 lane0");
        pop_one(8'h22, "R1 lane1");
        pop_one(8'h33, "R1 lane2");
        pop_one(8'h44, "R1 lane3");
        chk("R8 drained", 32'(tx_byte_valid), 0);

        // R6 transmit flush
        flush_q(1, 0);
        chk("R6 tx_words flushed", 32'(tx_words), 0);
        chk("R6 tx_empty flushed", 32'(tx_empty), 1);

        // R2: fill back to back, then overflow at the word boundary
        for (int i = 0; i < TXD / 4; i++) begin
            do_write({8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)}, flag);
        end
        chk("R3 tx_words full", 32'(tx_words), TXD / 4);
        do_write(32'hFFEE_DDCC, flag);
        chk("R2 overflow at boundary", 32'(flag), 1);
        chk("R2 tx_full set", 32'(tx_full), 1);
        chk("R2 tx_words unchanged", 32'(tx_words), TXD / 4);

        // R2: overflow partway through a word
        pop_one(8'h00, "R1 order after fill");
        pop_one(8'h01, "R1 order after fill");
        do_write(32'hDDCC_BBAA, flag);
        chk("R2 partial overflow", 32'(flag), 1);
        chk("R2 tx_words after partial", 32'(tx_words), TXD / 4);
        drained = 0; last0 = 0; last1 = 0;
        while (tx_byte_valid) begin
            last1 = last0; last0 = tx_byte;
            tx_pop = 1;
            @(negedge clk);
            tx_pop = 0;
            drained++;
        end
        chk("R2 bytes kept", 32'(drained), TXD);
        chk("R2 last kept lane0", 32'(last1), 32'hAA);
        chk("R2 last kept lane1", 32'(last0), 32'hBB);
        flush_q(1, 0);
        chk("R6 tx_full cleared", 32'(tx_full), 0);

        // R8: shift side pops while a word is loaded
        tx_pop = 1;
        do_write(32'h0807_0605, flag);
        repeat (2) @(negedge clk);
        tx_pop = 0;
        chk("R8 concurrent drain", 32'(tx_byte_valid), 0);

        // R4 / R5: aligned read then partial drain then empty read
        for (int i = 0; i < 6; i++) push_one(8'hA0 + 8'(i));
        chk("R8 rx_empty cleared", 32'(rx_empty), 0);
        do_read(w, flag);
        chk("R4 packed word", w, 32'hA3A2_A1A0);
        chk("R5 no underflow", 32'(flag), 0);
        do_read(w, flag);
        chk("R5 partial word", w, 32'h0000_A5A4);
        chk("R5 underflow pulse", 32'(flag), 1);
        chk("R5 rx_empty set", 32'(rx_empty), 1);
        do_read(w, flag);
        chk("R5 empty read", w, 32'h0);
        chk("R5 underflow on empty", 32'(flag), 1);

        // R8 / R4: overfill the receive queue, read clears full
        for (int i = 0; i <= RXD; i++) push_one(8'(i));
        chk("R8 rx_full on drop", 32'(rx_full), 1);
        do_read(w, flag);
        chk("R4 rx_full cleared", 32'(rx_full), 0);
        chk("R4 first word", w, 32'h0302_0100);
        // R9 back-to-back reads
        do_read(w, flag);
        do_read(w, flag);
        do_read(w, flag);
        chk("R9 back-to-back read", w, 32'h0F0E_0D0C);
        flush_q(0, 1);
        chk("R6 rx_empty flushed", 32'(rx_empty), 1);
        chk("R6 rx_full flushed", 32'(rx_full), 0);

        // R10: dropped push in the acceptance clock of a read
        for (int i = 0; i < RXD; i++) push_one(8'h40 + 8'(i % 16));
        chk("R8 full queue no flag", 32'(rx_full), 0);
        rx_push = 1; rx_byte = 8'hEE; rd_req = 1;
        @(negedge clk);
        rx_push = 0; rd_req = 0;
        while (acc_wait) @(negedge clk);
        chk("R10 set wins", 32'(rx_full), 1);
        chk("R4 word after collision", rd_data, 32'h4342_4140);
        flush_q(1, 1);
        repeat (3) @(negedge clk);

        fin = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule